// File: doc/BRIEF.md
# Flash Chip-Select Segment Window Decoder

This block keeps one segment register for each flash chip select, up to five of them. A segment register places that select's window inside one shared flash mapping window. Both of its edges are counted in 8 MB units. Software-side logic updates a segment through a write port. The block checks every write against a fixed set of hardware rules before it stores the value. The start of select 0 is pinned to the window base. As an option, the end of the last select is pinned to its default. A segment that lies entirely outside the window is refused. Misaligned writes and overlapping writes are still stored, but each one raises a flag. The three error flags are sticky until they are cleared.

A second port turns bus addresses into a one-hot chip-select match and the byte offset inside the matched segment. It follows valid/ready rules on both sides. A request is accepted on a rising edge when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in that same cycle. A response stays on `resp_valid` with all of its fields unchanged until `resp_ready` takes it. The write port has `wr_ready` tied high, so each write with `wr_valid` high is taken in one cycle.

The window base, the window size, the default segment sizes and the end lock are parameters.

Top module: `flash_seg_decoder`

## Requirements
- R1: Out of reset, select 0 covers the window base for FIRST_UNITS units (64 MB by default). Each later select follows the previous one for REST_UNITS units (32 MB by default). Register encoding: bits [31:24] hold the end unit, bits [23:16] hold the start unit (address bits 30:23), and bits [15:0] read as zero.
- R2: On a write to select 0, the start field is replaced by the window base unit before validation and storage. The end field is kept.
- R3: When END_LOCK is 1, a write to the last select has its end field replaced by that select's default end unit.
- R4: A corrected write is refused when its end unit is at or below the window base unit, or its start unit is above (base + size) / 8 MB. A refused write leaves the register unchanged and sets the invalid flag (`err_invalid`).
- R5: A stored write whose end is above its start, and whose start is not a multiple of (end − start), sets `err_misalign`.
- R6: A stored write that intersects another select's non-empty segment (new end > other start and new start < other end) sets `err_overlap`.
- R7: A write whose raw 32-bit value equals the current register changes no register and raises no flag.
- R8: Flags are sticky. `err_clr` bit 0 clears invalid, bit 1 clears misalign and bit 2 clears overlap. A flag set in the same cycle as its clear stays set.
- R9: A decode request matches select i when address bit 31 is 0, the segment is non-empty, and start_i ≤ addr[30:23] < end_i. The response carries the one-hot `resp_sel` and `resp_offset` = addr − start_i·8 MB. If nothing matches, `resp_miss` is 1 and `resp_sel` is 0.
- R10: When several selects match, only the lowest-numbered one is reported.
- R11: `req_ready` = !`resp_valid` || `resp_ready`. The response appears one cycle after acceptance and holds steady while it is stalled.
- R12: `wr_ready` is always 1. A write updates the register and the flags on the clock edge that accepts it. A write to a select number ≥ NUM_CS is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Segment write strobe |
| wr_ready | output | 1 | Always high |
| wr_cs | input | CS_W | Select number being written |
| wr_data | input | 32 | New segment register value |
| rd_cs | input | CS_W | Select number to read back |
| rd_data | output | 32 | Register of `rd_cs`, zero if out of range |
| req_valid | input | 1 | Decode request valid |
| req_ready | output | 1 | Decode request accepted this cycle |
| req_addr | input | 32 | Bus address to decode |
| resp_valid | output | 1 | Decode result valid |
| resp_ready | input | 1 | Consumer takes the result |
| resp_sel | output | NUM_CS | One-hot matched select |
| resp_miss | output | 1 | No select matched |
| resp_offset | output | 32 | Offset inside the matched segment |
| err_invalid | output | 1 | Sticky: refused out-of-window write |
| err_misalign | output | 1 | Sticky: misaligned segment stored |
| err_overlap | output | 1 | Sticky: overlapping segment stored |
| err_clr | input | 3 | Write-one-to-clear strobes for the flags |

## Verification
The bench builds the block with five selects, a 256 MB window at 0x2000_0000, the default 64/32 MB layout and END_LOCK set to 1. The lock setting makes the rule that pins the last select's end reachable. The default segments fill the window only up to 0x2C00_0000, which leaves an unmapped tail for miss cases. By moving segments, the bench produces holes, misaligned sizes and an overlap that lets two selects match the same address. That overlap is what exercises the priority rule. A consumer that stalls in a fixed pattern keeps responses parked on the output while new requests arrive.

// File: rtl/fseg_pkg.sv
package fseg_pkg;
  localparam int ADDR_W     = 32;
  localparam int UNIT_SHIFT = 23;
  localparam int FIELD_W    = 8;
  localparam int PAD_W      = ADDR_W - 2 * FIELD_W;
  localparam int ERR_W      = 3;
  localparam int ERR_INVALID  = 0;
  localparam int ERR_MISALIGN = 1;
  localparam int ERR_OVERLAP  = 2;

  typedef logic [FIELD_W-1:0] unit_t;

  typedef struct packed {
    unit_t            end_u;
    unit_t            start_u;
    logic [PAD_W-1:0] pad;
  } seg_reg_t;

  function automatic seg_reg_t make_seg(unit_t s, unit_t e);
    seg_reg_t r;
    r.end_u   = e;
    r.start_u = s;
    r.pad     = '0;
    return r;
  endfunction

  function automatic unit_t dflt_start(int base_u, int first_u, int rest_u, int idx);
    int v;
    v = (idx == 0) ? base_u : base_u + first_u + (idx - 1) * rest_u;
    return unit_t'(v);
  endfunction

  function automatic unit_t dflt_end(int base_u, int first_u, int rest_u, int idx);
    int v;
    v = int'(dflt_start(base_u, first_u, rest_u, idx)) + ((idx == 0) ? first_u : rest_u);
    return unit_t'(v);
  endfunction

  // Restoring remainder, one subtract per numerator bit.
  function automatic unit_t unit_rem(unit_t num, unit_t den);
    logic [FIELD_W:0] r;
    r = '0;
    for (int b = FIELD_W - 1; b >= 0; b--) begin
      r = {r[FIELD_W-1:0], num[b]};
      if (r >= {1'b0, den}) r = r - {1'b0, den};
    end
    return r[FIELD_W-1:0];
  endfunction
endpackage

// File: rtl/fseg_check.sv
module fseg_check
  import fseg_pkg::*;
#(
  parameter int NUM_CS   = 5,
  parameter int CS_W     = 3,
  parameter int BASE_U   = 64,
  parameter int LIM_U    = 96,
  parameter bit END_LOCK = 1'b0,
  parameter int LOCK_END = 88
) (
  input  logic [CS_W-1:0]          wr_cs,
  input  logic [ADDR_W-1:0]        wr_data,
  input  seg_reg_t [NUM_CS-1:0]    segs,
  output seg_reg_t                 fixed,
  output logic                     same,
  output logic                     inval,
  output logic                     misal,
  output logic                     ovl
);
  seg_reg_t            raw;
  seg_reg_t            cur;
  unit_t               s_new;
  unit_t               e_new;
  unit_t               span;
  logic [NUM_CS-1:0]   clash;

  assign raw = seg_reg_t'(wr_data);

  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (wr_cs == CS_W'(i)) cur = segs[i];
    end
  end

  assign same = (wr_data == ADDR_W'(cur));

  always_comb begin
    s_new = raw.start_u;
    e_new = raw.end_u;
    if (wr_cs == '0) s_new = unit_t'(BASE_U);
    if (END_LOCK && (wr_cs == CS_W'(NUM_CS - 1))) e_new = unit_t'(LOCK_END);
  end

  assign fixed = make_seg(s_new, e_new);
  assign inval = ({1'b0, e_new} <= (FIELD_W+1)'(BASE_U)) ||
                 ({1'b0, s_new} >  (FIELD_W+1)'(LIM_U));
  assign span  = e_new - s_new;
  assign misal = (e_new > s_new) && (unit_rem(s_new, span) != '0);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_clash
    assign clash[g] = (wr_cs != CS_W'(g)) &&
                      (segs[g].end_u > segs[g].start_u) &&
                      (e_new > segs[g].start_u) &&
                      (s_new < segs[g].end_u);
  end

  assign ovl = |clash;
endmodule

// File: rtl/fseg_store.sv
module fseg_store
  import fseg_pkg::*;
#(
  parameter int NUM_CS      = 5,
  parameter int CS_W        = 3,
  parameter int BASE_U      = 64,
  parameter int FIRST_UNITS = 8,
  parameter int REST_UNITS  = 4,
  parameter bit END_LOCK    = 1'b0,
  parameter int LOCK_END    = 88
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_fire,
  input  logic [CS_W-1:0]        wr_cs,
  input  seg_reg_t               fixed,
  input  logic                   same,
  input  logic                   inval,
  input  logic                   misal,
  input  logic                   ovl,
  input  logic [ERR_W-1:0]       err_clr,
  output seg_reg_t [NUM_CS-1:0]  segs,
  output logic [ERR_W-1:0]       err
);
  seg_reg_t [NUM_CS-1:0] seg_q;
  logic [ERR_W-1:0]      err_q;
  logic                  live;
  logic                  apply;
  logic [ERR_W-1:0]      err_set;

  assign live  = wr_fire && !same;
  assign apply = live && !inval;

  always_comb begin
    err_set               = '0;
    err_set[ERR_INVALID]  = live && inval;
    err_set[ERR_MISALIGN] = apply && misal;
    err_set[ERR_OVERLAP]  = apply && ovl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        seg_q[i] <= make_seg(dflt_start(BASE_U, FIRST_UNITS, REST_UNITS, i),
                             dflt_end(BASE_U, FIRST_UNITS, REST_UNITS, i));
      end
      err_q <= '0;
    end else begin
      if (apply) seg_q[wr_cs] <= fixed;
      err_q <= (err_q & ~err_clr) | err_set;
    end
  end

  assign segs = seg_q;
  assign err  = err_q;

  // R1
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q[0].pad == '0 && seg_q[NUM_CS-1].pad == '0);

  // R2
  cs0_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q[0].start_u == unit_t'(BASE_U));

  // R4
  refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !same && inval) |=> $stable(seg_q) && err_q[ERR_INVALID]);

  // R7
  same_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && same && err_clr == '0) |=> $stable(seg_q) && $stable(err_q));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[ERR_OVERLAP] && !err_clr[ERR_OVERLAP]) |=> err_q[ERR_OVERLAP]);

  if (END_LOCK) begin : g_lock_chk
    // R3
    end_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_q[NUM_CS-1].end_u == unit_t'(LOCK_END));
  end
endmodule

// File: rtl/fseg_lookup.sv
module fseg_lookup
  import fseg_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  seg_reg_t [NUM_CS-1:0]  segs,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  output logic                   resp_valid,
  input  logic                   resp_ready,
  output logic [NUM_CS-1:0]      resp_sel,
  output logic                   resp_miss,
  output logic [ADDR_W-1:0]      resp_offset
);
  unit_t               au;
  logic [NUM_CS-1:0]   hit;
  logic [NUM_CS-1:0]   pick;
  unit_t               base_pick;
  logic [ADDR_W-1:0]   off_d;
  logic                accept;

  assign au = req_addr[UNIT_SHIFT+FIELD_W-1:UNIT_SHIFT];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_hit
    assign hit[g] = !req_addr[ADDR_W-1] &&
                    (segs[g].end_u > segs[g].start_u) &&
                    (au >= segs[g].start_u) &&
                    (au < segs[g].end_u);
  end

  always_comb begin
    pick      = '0;
    base_pick = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hit[i] && (pick == '0)) begin
        pick[i]   = 1'b1;
        base_pick = segs[i].start_u;
      end
    end
  end

  assign off_d     = req_addr - {{(ADDR_W-FIELD_W-UNIT_SHIFT){1'b0}}, base_pick, {UNIT_SHIFT{1'b0}}};
  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_sel    <= '0;
      resp_miss   <= 1'b0;
      resp_offset <= '0;
    end else if (accept) begin
      resp_valid  <= 1'b1;
      resp_sel    <= pick;
      resp_miss   <= (pick == '0);
      resp_offset <= (pick == '0) ? '0 : off_d;
    end else if (resp_ready) begin
      resp_valid  <= 1'b0;
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> resp_valid && $stable(resp_sel) &&
                                    $stable(resp_offset) && $stable(resp_miss));

  // R10
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot0(resp_sel));

  // R9
  miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_miss == (resp_sel == '0)));
endmodule

// File: rtl/flash_seg_decoder.sv
module flash_seg_decoder
  import fseg_pkg::*;
#(
  parameter int          NUM_CS      = 5,
  parameter logic [31:0] WIN_BASE    = 32'h2000_0000,
  parameter logic [31:0] WIN_SIZE    = 32'h1000_0000,
  parameter int          FIRST_UNITS = 8,
  parameter int          REST_UNITS  = 4,
  parameter bit          END_LOCK    = 1'b0,
  localparam int         CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CS_W-1:0]   wr_cs,
  input  logic [31:0]       wr_data,
  input  logic [CS_W-1:0]   rd_cs,
  output logic [31:0]       rd_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [NUM_CS-1:0] resp_sel,
  output logic              resp_miss,
  output logic [31:0]       resp_offset,
  output logic              err_invalid,
  output logic              err_misalign,
  output logic              err_overlap,
  input  logic [2:0]        err_clr
);
  localparam int              BASE_U   = int'(WIN_BASE >> UNIT_SHIFT);
  localparam logic [ADDR_W:0] LIM_A    = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};
  localparam int              LIM_U    = int'(LIM_A >> UNIT_SHIFT);
  localparam int              LOCK_END = int'(dflt_end(BASE_U, FIRST_UNITS, REST_UNITS, NUM_CS - 1));

  seg_reg_t [NUM_CS-1:0] segs;
  seg_reg_t              fixed;
  logic                  same, inval, misal, ovl;
  logic                  wr_fire;
  logic [ERR_W-1:0]      err;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && (int'(wr_cs) < NUM_CS);

  fseg_check #(
    .NUM_CS(NUM_CS), .CS_W(CS_W), .BASE_U(BASE_U), .LIM_U(LIM_U),
    .END_LOCK(END_LOCK), .LOCK_END(LOCK_END)
  ) u_check (
    .wr_cs(wr_cs), .wr_data(wr_data), .segs(segs), .fixed(fixed),
    .same(same), .inval(inval), .misal(misal), .ovl(ovl)
  );

  fseg_store #(
    .NUM_CS(NUM_CS), .CS_W(CS_W), .BASE_U(BASE_U), .FIRST_UNITS(FIRST_UNITS),
    .REST_UNITS(REST_UNITS), .END_LOCK(END_LOCK), .LOCK_END(LOCK_END)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_cs(wr_cs), .fixed(fixed),
    .same(same), .inval(inval), .misal(misal), .ovl(ovl), .err_clr(err_clr),
    .segs(segs), .err(err)
  );

  fseg_lookup #(.NUM_CS(NUM_CS)) u_lookup (
    .clk(clk), .rst_n(rst_n), .segs(segs),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_sel(resp_sel),
    .resp_miss(resp_miss), .resp_offset(resp_offset)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (rd_cs == CS_W'(i)) rd_data = segs[i];
    end
  end

  assign err_invalid  = err[ERR_INVALID];
  assign err_misalign = err[ERR_MISALIGN];
  assign err_overlap  = err[ERR_OVERLAP];

  // R12
  wr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
endmodule

// File: tb/test_flash_seg_decoder.sv
module test_flash_seg_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_cs = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_cs = '0;
  logic [31:0] rd_data;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [NCS-1:0] resp_sel;
  logic        resp_miss;
  logic [31:0] resp_offset;
  logic        err_invalid, err_misalign, err_overlap;
  logic [2:0]  err_clr = '0;

  flash_seg_decoder #(.NUM_CS(NCS), .END_LOCK(1'b1)) i_flash_seg_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_cs(wr_cs), .wr_data(wr_data), .rd_cs(rd_cs), .rd_data(rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_sel(resp_sel),
    .resp_miss(resp_miss), .resp_offset(resp_offset), .err_invalid(err_invalid),
    .err_misalign(err_misalign), .err_overlap(err_overlap), .err_clr(err_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [NCS-1:0] sel;
    logic           miss;
    logic [31:0]    off;
    string          tag;
  } exp_t;

  exp_t        exq[$];
  logic [31:0] exp_r [NCS];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input string tag);
    exp_t r;
    r.sel = '0; r.miss = 1'b1; r.off = '0; r.tag = tag;
    for (int i = 0; i < NCS; i++) begin
      logic [7:0] s, e;
      s = exp_r[i][23:16];
      e = exp_r[i][31:24];
      if (r.miss && !a[31] && e > s && a[30:23] >= s && a[30:23] < e) begin
        r.sel = NCS'(1) << i;
        r.miss = 1'b0;
        r.off = a - {1'b0, s, 23'd0};
      end
    end
    return r;
  endfunction

  task automatic dec(input logic [31:0] a, input string tag);
    exq.push_back(model(a, tag));
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] cs, input logic [31:0] d, input logic [2:0] clr);
    @(negedge clk);
    wr_valid = 1'b1; wr_cs = cs; wr_data = d; err_clr = clr;
    @(negedge clk);
    wr_valid = 1'b0; err_clr = '0;
  endtask

  task automatic clr(input logic [2:0] m);
    @(negedge clk);
    err_clr = m;
    @(negedge clk);
    err_clr = '0;
  endtask

  task automatic chk_reg(input int i, input string tag);
    rd_cs = 3'(i);
    #1;
    chk(rd_data == exp_r[i], tag, rd_data, exp_r[i]);
  endtask

  task automatic chk_flags(input logic [2:0] exp, input string tag);
    logic [2:0] act;
    act = {err_overlap, err_misalign, err_invalid};
    chk(act == exp, tag, 32'(act), 32'(exp));
  endtask

  // Consumer: stalls one cycle in four.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      resp_ready = (cnt % 4) != 3;
    end
  end

  // Monitor / scoreboard
  initial begin
    bit             stalled = 1'b0;
    logic [NCS-1:0] h_sel;
    logic [31:0]    h_off;
    forever begin
      @(negedge clk);
      #2;
      if (stalled) begin
        chk(resp_valid && resp_sel == h_sel && resp_offset == h_off,
            "R11 held response", {resp_offset}, {h_off});
      end
      if (resp_valid && resp_ready) begin
        if (exq.size() == 0) begin
          chk(1'b0, "R11 unexpected response", 32'(resp_sel), 32'd0);
        end else begin
          exp_t e;
          e = exq.pop_front();
          chk(resp_sel == e.sel, {e.tag, " sel"}, 32'(resp_sel), 32'(e.sel));
          chk(resp_miss == e.miss, {e.tag, " miss"}, 32'(resp_miss), 32'(e.miss));
          chk(resp_offset == e.off, {e.tag, " offset"}, resp_offset, e.off);
        end
      end
      stalled = resp_valid && !resp_ready;
      h_sel = resp_sel;
      h_off = resp_offset;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    exp_r[0] = 32'h4840_0000;
    exp_r[1] = 32'h4C48_0000;
    exp_r[2] = 32'h504C_0000;
    exp_r[3] = 32'h5450_0000;
    exp_r[4] = 32'h5854_0000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset layout, R12 ready, R11 idle output
    for (int i = 0; i < NCS; i++) chk_reg(i, "R1 reset register");
    chk_flags(3'b000, "R1 flags clear at reset");
    chk(wr_ready == 1'b1, "R12 wr_ready", 32'(wr_ready), 32'd1);
    chk(resp_valid == 1'b0, "R11 idle resp_valid", 32'(resp_valid), 32'd0);

    // R9 decode on default layout
    dec(32'h2000_0000, "R9 cs0 base");
    dec(32'h23FF_FFFC, "R9 cs0 top");
    dec(32'h2400_0000, "R9 cs1 base");
    dec(32'h2BFF_FFFF, "R9 cs4 last byte");
    dec(32'h2C00_0000, "R9 unmapped tail");
    dec(32'h1FFF_FFFF, "R9 below window");
    dec(32'hA000_0000, "R9 bit31 set");
    drain();

    // R2 start of cs0 pinned
    wr(3'd0, 32'h4477_1234, 3'b000);
    exp_r[0] = 32'h4440_0000;
    chk_reg(0, "R2 cs0 start locked");
    chk_flags(3'b000, "R2 no flags");
    dec(32'h2200_0000, "R9 shrunk cs0 miss");
    dec(32'h21FF_FFFF, "R9 shrunk cs0 hit");
    drain();

    // R4 refused writes
    wr(3'd1, 32'h4030_0000, 3'b000);
    chk_reg(1, "R4 end at base refused");
    chk_flags(3'b001, "R4 invalid flag");
    clr(3'b001);
    chk_flags(3'b000, "R8 clear invalid");
    wr(3'd2, 32'h7061_0000, 3'b000);
    chk_reg(2, "R4 start past limit refused");
    chk_flags(3'b001, "R4 invalid flag again");
    // R8 set wins over clear in the same cycle
    wr(3'd2, 32'h7061_0000, 3'b001);
    chk_flags(3'b001, "R8 set beats clear");
    clr(3'b001);

    // R5 misaligned but stored
    wr(3'd1, 32'h4C49_0000, 3'b000);
    exp_r[1] = 32'h4C49_0000;
    chk_reg(1, "R5 misaligned stored");
    chk_flags(3'b010, "R5 misalign flag only");
    clr(3'b100);
    chk_flags(3'b010, "R8 other clear bit keeps flag");
    clr(3'b010);
    chk_flags(3'b000, "R8 misalign cleared");
    dec(32'h2480_0000, "R9 moved cs1");
    dec(32'h2400_0000, "R9 hole after move");
    drain();

    // R6 overlap stored, R10 priority
    wr(3'd3, 32'h504C_0000, 3'b000);
    exp_r[3] = 32'h504C_0000;
    chk_reg(3, "R6 overlapping stored");
    chk_flags(3'b100, "R6 overlap flag only");
    dec(32'h2600_0000, "R10 lowest select wins");
    drain();
    clr(3'b100);

    // R7 equal value write is silent even though it overlaps cs3
    wr(3'd2, 32'h504C_0000, 3'b000);
    chk_reg(2, "R7 equal write keeps register");
    chk_flags(3'b000, "R7 equal write raises nothing");

    // R3 end of last select pinned
    wr(3'd4, 32'h5C54_0000, 3'b000);
    chk_reg(4, "R3 end locked");
    chk_flags(3'b000, "R3 no flags");
    wr(3'd4, 32'h5C56_0000, 3'b000);
    exp_r[4] = 32'h5856_0000;
    chk_reg(4, "R3 start moves, end locked");
    dec(32'h2B00_0000, "R9 moved cs4");
    dec(32'h2A00_0000, "R9 hole before cs4");
    drain();

    // R12 out-of-range select ignored
    wr(3'd5, 32'h1234_0000, 3'b000);
    for (int i = 0; i < NCS; i++) chk_reg(i, "R12 out-of-range write ignored");
    chk_flags(3'b000, "R12 no flags from ignored write");
    rd_cs = 3'd6;
    #1;
    chk(rd_data == 32'd0, "R12 out-of-range read", rd_data, 32'd0);

    // R11 back-to-back burst under consumer stalls
    for (int k = 0; k < 24; k++) dec(32'h2000_0000 + 32'(k) * 32'h0080_0000 + 32'(k * 4), "R11 burst");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule